// File: doc/BRIEF.md
# Blocked Multithreading Thread Controller

This block decides which hardware thread feeds the next instruction into a single-issue pipeline. It holds one program counter per thread and one state per thread (idle, ready, running or waiting). Each issued fetch leaves the block as a PC, a thread tag and a valid bit. Because every context is held inside the block, a thread switch loads nothing from memory.

Two scheduling modes are selected by one input. In interleaved mode the block chooses a thread again on every cycle and pays no penalty for a switch. In blocked mode one thread keeps issuing until it reports a long-latency event, such as a remote memory access. That thread then waits, one bubble cycle follows, and another ready thread takes over. A waiting thread becomes ready again on its completion strobe and continues from the PC after its last issued instruction. A redirect port overwrites any thread's PC. A start port brings an idle thread to life.

Top module: `bmt_thread_ctl`

## Requirements
- R1: While reset is high the outputs read valid 0, tag 0, PC 0. After reset only thread 0 is ready, at PC 0, and the first edge after reset issues it.
- R2: The tag is the thread number in binary (0 to 3). Each issue from a thread without a redirect moves that thread's PC up by 4.
- R3: In blocked mode the running thread issues on every cycle until a latency event names it, whatever the state of the other threads.
- R4: In blocked mode, a latency event on the running thread gives exactly one cycle with valid low. The next ready thread, searching upward from the last running tag and wrapping, then issues.
- R5: In interleaved mode the block picks a new thread on every cycle, in the same wrapping order. A latency event makes the switch with no bubble, and a lone ready thread issues on back-to-back cycles.
- R6: A completion strobe makes a waiting thread eligible again. Its next issue uses the PC following its last issued one.
- R7: If a completion strobe and a latency event name the same waiting thread in one cycle, the thread stays waiting.
- R8: When no thread can be selected, valid is low and the tag and PC outputs keep their last values.
- R9: A redirect (tag, target) replaces that thread's PC. The thread's next issue uses the target, including a redirect that arrives in the same cycle as the selection.
- R10: A start (tag, PC) makes an idle thread ready at that PC. A start aimed at a thread that is not idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_mode | input | 1 | 1 = blocked mode, 0 = interleaved mode |
| start_vld | input | 1 | Start request |
| start_tid | input | 2 | Thread to start |
| start_pc | input | 32 | Initial PC of the started thread |
| lat_vld | input | 1 | Latency event strobe |
| lat_tid | input | 2 | Thread raising the latency event |
| done | input | 4 | Per-thread completion strobes |
| redir_vld | input | 1 | Redirect request |
| redir_tid | input | 2 | Thread to redirect |
| redir_pc | input | 32 | Redirect target |
| fetch_vld | output | 1 | An instruction is issued this cycle |
| fetch_tid | output | 2 | Tag of the issuing thread |
| fetch_pc | output | 32 | Fetch PC |

## Verification
One long blocked-mode sequence starts threads, raises latency events on the running thread and returns waiting threads with completion strobes. It shows the single bubble, the wrap-around search order and continuation from the saved PC. It also drives the sequence into a state where every thread is waiting, and it places a completion strobe and a latency event on the same thread in one cycle. The same run then changes to interleaved mode, where the tag must rotate on every cycle and a latency event must skip the thread with no gap. A start aimed at a busy thread shows up later as an unchanged PC. Short directed runs cover the reset values, a lone thread in interleaved mode and a redirect of the running thread.

// File: rtl/bmt_thread_ctl.sv
module bmt_thread_ctl #(
  parameter int NTHR    = 4,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4,
  localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_mode,
  input  logic             start_vld,
  input  logic [TID_W-1:0] start_tid,
  input  logic [PC_W-1:0]  start_pc,
  input  logic             lat_vld,
  input  logic [TID_W-1:0] lat_tid,
  input  logic [NTHR-1:0]  done,
  input  logic             redir_vld,
  input  logic [TID_W-1:0] redir_tid,
  input  logic [PC_W-1:0]  redir_pc,
  output logic             fetch_vld,
  output logic [TID_W-1:0] fetch_tid,
  output logic [PC_W-1:0]  fetch_pc
);

  typedef enum logic [1:0] {T_IDLE, T_READY, T_RUN, T_WAIT} tstate_e;

  tstate_e          st_q  [NTHR];
  tstate_e          st_ev [NTHR];
  tstate_e          st_nx [NTHR];
  logic [PC_W-1:0]  pc_q  [NTHR];
  logic [PC_W-1:0]  pc_base [NTHR];
  logic [NTHR-1:0]  cand;
  logic             vld_q, keep, bubble, any_cand, issue, armed;
  logic [TID_W-1:0] cur_q, pick, sel;
  logic [PC_W-1:0]  opc_q;

  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      pc_base[i] = pc_q[i];
      st_ev[i]   = st_q[i];
      if (redir_vld && redir_tid == TID_W'(i))
        pc_base[i] = redir_pc;
      if (start_vld && start_tid == TID_W'(i) && st_q[i] == T_IDLE) begin
        pc_base[i] = start_pc;
        st_ev[i]   = T_READY;
      end
      if (lat_vld && lat_tid == TID_W'(i) && st_q[i] != T_IDLE)
        st_ev[i] = T_WAIT;
      else if (done[i] && st_q[i] == T_WAIT)
        st_ev[i] = T_READY;
      cand[i] = (st_ev[i] == T_READY) || (st_ev[i] == T_RUN);
    end
  end

  always_comb begin
    pick     = cur_q;
    any_cand = 1'b0;
    for (int k = NTHR; k >= 1; k--) begin
      if (cand[(int'(cur_q) + k) % NTHR]) begin
        pick     = TID_W'((int'(cur_q) + k) % NTHR);
        any_cand = 1'b1;
      end
    end
  end

  assign keep   = blk_mode && vld_q && (st_ev[cur_q] == T_RUN);
  assign bubble = blk_mode && vld_q && !keep;
  assign issue  = keep || (!bubble && any_cand);
  assign sel    = keep ? cur_q : pick;

  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      if (issue && sel == TID_W'(i)) st_nx[i] = T_RUN;
      else if (st_ev[i] == T_RUN)    st_nx[i] = T_READY;
      else                           st_nx[i] = st_ev[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTHR; i++) begin
        st_q[i] <= (i == 0) ? T_READY : T_IDLE;
        pc_q[i] <= '0;
      end
      vld_q <= 1'b0;
      cur_q <= '0;
      opc_q <= '0;
      armed <= 1'b0;
    end else begin
      for (int i = 0; i < NTHR; i++) begin
        st_q[i] <= st_nx[i];
        pc_q[i] <= (issue && sel == TID_W'(i)) ? pc_base[i] + PC_W'(PC_STEP) : pc_base[i];
      end
      vld_q <= issue;
      armed <= 1'b1;
      if (issue) begin
        cur_q <= sel;
        opc_q <= pc_base[sel];
      end
    end
  end

  assign fetch_vld = vld_q;
  assign fetch_tid = cur_q;
  assign fetch_pc  = opc_q;

  // R2: a valid tag always names the thread recorded as running
  p_tag_running_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_vld |-> st_q[fetch_tid] == T_RUN);

  // R2: back-to-back issue from one thread without redirect steps the PC
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && fetch_vld && !(redir_vld && redir_tid == fetch_tid)) |=>
      (!fetch_vld || fetch_tid != $past(fetch_tid) ||
       fetch_pc == $past(fetch_pc) + PC_W'(PC_STEP)));

  // R3: blocked mode stays on the running thread without a latency event on it
  p_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (blk_mode && fetch_vld && !(lat_vld && lat_tid == fetch_tid)) |=>
      (fetch_vld && fetch_tid == $past(fetch_tid)));

  // R4: latency event on the running thread in blocked mode yields a bubble
  p_bubble_r4: assert property (@(posedge clk) disable iff (rst)
    (blk_mode && fetch_vld && lat_vld && lat_tid == fetch_tid) |=> !fetch_vld);

  // R8: outputs hold while nothing issues
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && !fetch_vld) |-> ($stable(fetch_pc) && $stable(fetch_tid)));

endmodule

// File: tb/bmt_thread_ctl_tb.sv
module bmt_thread_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        mode;
    logic        sv;  logic [1:0] stid; logic [15:0] spc;
    logic        lv;  logic [1:0] ltid;
    logic [3:0]  dn;
    logic        rv;  logic [1:0] rtid; logic [15:0] rpc;
    logic        ev;  logic [1:0] etid; logic [15:0] epc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd0,16'h000, 8'd2},  // R2 t0 first
    '{1'b1, 1'b1,2'd1,16'h100, 1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd0,16'h004, 8'd3},  // R3 start t1
    '{1'b1, 1'b1,2'd2,16'h200, 1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd0,16'h008, 8'd3},  // R3 start t2
    '{1'b1, 1'b0,2'd0,16'h0,   1'b1,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b0,2'd0,16'h008, 8'd4},  // R4 bubble
    '{1'b1, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd1,16'h100, 8'd4},  // R4 next t1
    '{1'b1, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd1,16'h104, 8'd2},
    '{1'b1, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0001, 1'b0,2'd0,16'h0,  1'b1,2'd1,16'h108, 8'd3},  // R3 t0 done, stay
    '{1'b1, 1'b0,2'd0,16'h0,   1'b1,2'd1, 4'b0000, 1'b0,2'd0,16'h0,  1'b0,2'd1,16'h108, 8'd4},
    '{1'b1, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd2,16'h200, 8'd4},  // R4 order t2
    '{1'b1, 1'b0,2'd0,16'h0,   1'b1,2'd2, 4'b0000, 1'b1,2'd0,16'h40, 1'b0,2'd2,16'h200, 8'd4},
    '{1'b1, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd0,16'h040, 8'd9},  // R9 wrap to t0
    '{1'b1, 1'b0,2'd0,16'h0,   1'b1,2'd1, 4'b0010, 1'b0,2'd0,16'h0,  1'b1,2'd0,16'h044, 8'd7},  // R7 t1 clash
    '{1'b1, 1'b0,2'd0,16'h0,   1'b1,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b0,2'd0,16'h044, 8'd4},
    '{1'b1, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b0,2'd0,16'h044, 8'd8},  // R8 none ready (R7 t1 still waits)
    '{1'b1, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0010, 1'b0,2'd0,16'h0,  1'b1,2'd1,16'h10C, 8'd6},  // R6 continuation
    '{1'b0, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0101, 1'b0,2'd0,16'h0,  1'b1,2'd2,16'h204, 8'd5},  // R5 interleave
    '{1'b0, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd0,16'h048, 8'd5},
    '{1'b0, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd1,16'h110, 8'd5},
    '{1'b0, 1'b0,2'd0,16'h0,   1'b1,2'd1, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd2,16'h208, 8'd5},  // R5 no bubble
    '{1'b0, 1'b1,2'd3,16'h300, 1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd3,16'h300, 8'd10}, // R10 start t3
    '{1'b0, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b1,2'd0,16'h80, 1'b1,2'd0,16'h080, 8'd9},  // R9 same cycle
    '{1'b0, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd2,16'h20C, 8'd5},
    '{1'b0, 1'b1,2'd2,16'h999, 1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd3,16'h304, 8'd10}, // R10 busy start
    '{1'b0, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd0,16'h084, 8'd2},
    '{1'b0, 1'b0,2'd0,16'h0,   1'b0,2'd0, 4'b0000, 1'b0,2'd0,16'h0,  1'b1,2'd2,16'h210, 8'd10}  // R10 t2 untouched
  };

  logic        clk = 1'b0, rst = 1'b1, blk_mode = 1'b1;
  logic        start_vld = 1'b0, lat_vld = 1'b0, redir_vld = 1'b0;
  logic [1:0]  start_tid = '0, lat_tid = '0, redir_tid = '0;
  logic [31:0] start_pc = '0, redir_pc = '0;
  logic [3:0]  done = '0;
  logic        fetch_vld;
  logic [1:0]  fetch_tid;
  logic [31:0] fetch_pc;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  bmt_thread_ctl dut_i (
    .clk(clk), .rst(rst), .blk_mode(blk_mode),
    .start_vld(start_vld), .start_tid(start_tid), .start_pc(start_pc),
    .lat_vld(lat_vld), .lat_tid(lat_tid), .done(done),
    .redir_vld(redir_vld), .redir_tid(redir_tid), .redir_pc(redir_pc),
    .fetch_vld(fetch_vld), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string rq, logic ev, logic [1:0] et, logic [31:0] ep);
    checks++;
    if (fetch_vld !== ev || fetch_tid !== et || fetch_pc !== ep) begin
      errors++;
      $display("FAIL %s: got vld=%0b tid=%0d pc=%h, expected vld=%0b tid=%0d pc=%h",
               rq, fetch_vld, fetch_tid, fetch_pc, ev, et, ep);
    end
  endtask

  task automatic idle_inputs();
    start_vld = 1'b0; lat_vld = 1'b0; redir_vld = 1'b0; done = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    rst = 1'b1; step();
    chk("R1 reset outputs", 1'b0, 2'd0, 32'h0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      blk_mode  = VECS[v].mode;
      start_vld = VECS[v].sv;  start_tid = VECS[v].stid; start_pc = 32'(VECS[v].spc);
      lat_vld   = VECS[v].lv;  lat_tid   = VECS[v].ltid;
      done      = VECS[v].dn;
      redir_vld = VECS[v].rv;  redir_tid = VECS[v].rtid; redir_pc = 32'(VECS[v].rpc);
      step();
      chk($sformatf("R%0d row %0d", VECS[v].req, v), VECS[v].ev, VECS[v].etid, 32'(VECS[v].epc));
    end

    // R1: first issue after reset, then R5 lone thread repeats in interleaved mode
    blk_mode = 1'b0;
    do_reset();
    step(); chk("R1 first issue", 1'b1, 2'd0, 32'h0);
    step(); chk("R5 lone thread", 1'b1, 2'd0, 32'h4);
    step(); chk("R5 lone thread", 1'b1, 2'd0, 32'h8);

    // R9: redirect of the running thread in blocked mode
    blk_mode = 1'b1;
    redir_vld = 1'b1; redir_tid = 2'd0; redir_pc = 32'h500;
    step(); chk("R9 redirect running", 1'b1, 2'd0, 32'h500);
    idle_inputs();
    step(); chk("R9 after redirect", 1'b1, 2'd0, 32'h504);

    // R3: latency event naming a non-running thread leaves blocked issue alone
    lat_vld = 1'b1; lat_tid = 2'd2;
    step(); chk("R3 foreign event", 1'b1, 2'd0, 32'h508);
    idle_inputs();

    // R1: reset in the middle of a run
    rst = 1'b1; step();
    chk("R1 mid-run reset", 1'b0, 2'd0, 32'h0);
    rst = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule